// File: doc/BRIEF.md
# Pipelined Burst SRAM Front-End

This block is a synchronous, pipelined memory front-end wrapped around a small storage array. Every control, address and data input is sampled on the rising clock edge. A new access starts when either of two active-low address strobes is asserted. The processor-side strobe always opens a read. The controller-side strobe opens a read or a write, depending on the write controls sampled with it. After the start address is loaded, a two-bit burst counter steps through four beats whenever the active-low advance input is asserted. A mode input picks the beat order: interleaved or linear.

Reads pass through a registered array stage and then an output register, which gives a 3-1-1-1 burst. Writes take their data one edge after the address and one edge after each advance. A write can be limited to individual byte lanes, or it can cover the whole word through the global write input. An asynchronous output enable gates only the data outputs. A strobe sampled while the three chip enables do not all agree deselects the block, and the outputs stop being driven one edge later.

Top module: `burst_sram_front`

## Requirements
- R1: The address input and the chip enables are taken only on an edge where `strobe_proc_n` or `strobe_ctrl_n` is low. On any other edge, a change of `addr` has no effect on the data being returned.
- R2: A strobe selects the block only when `en0_n` is 0, `en1` is 1 and `en2_n` is 0. If any one of these disagrees, the block is deselected.
- R3: If the block was not returning data and a selecting read strobe is sampled at edge E0, `q_drive` stays low after E0 and after E0+1. The first beat is presented after E0+2.
- R4: With `burst_lin`=0 sampled at the strobe, the two low address bits of beat k are the loaded low bits XOR k, for k = 0..3.
- R5: With `burst_lin`=1 sampled at the strobe, the two low address bits of beat k are (loaded low bits + k) mod 4. In both modes the upper address bits never change within a burst.
- R6: The counter moves one beat on each edge where `adv_n` is 0 and no strobe is low. When `adv_n` is 1, the current beat is held and the same data repeats. A read beat advanced at edge E appears after edge E+2.
- R7: A processor strobe always starts a read. This holds even when the controller strobe and the write controls are also asserted on the same edge, so no array word changes.
- R8: A controller strobe with `all_wr_n`=0 writes all byte lanes, whatever `byte_we_n` holds. The first word is taken from `wdata` on the next edge, and one further word is taken on the edge after each advance.
- R9: A controller strobe with `all_wr_n`=1 and `byte_gate_n`=0 writes only the lanes whose `byte_we_n` bit i is 0. Lane i is bits [8i+7:8i]. All other lanes keep their contents.
- R10: A controller strobe with both `all_wr_n` and `byte_gate_n` high starts a read and changes no word.
- R11: `q_drive` equals the registered valid flag AND NOT `oe_n`, with no clock involved, and `q` is 0 whenever `q_drive` is 0. `oe_n` has no effect on the pipeline contents.
- R12: If a deselecting strobe is sampled at edge E, `q_drive` is low after edge E+1, even when a read was in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (6) | Word address, loaded on a strobe |
| strobe_proc_n | input | 1 | Processor address strobe, active low, always a read |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| burst_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| en0_n | input | 1 | Chip enable, active low |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| all_wr_n | input | 1 | Global write of every lane, active low |
| byte_gate_n | input | 1 | Gate for the per-lane write enables, active low |
| byte_we_n | input | NB (4) | Per-lane write enables, active low |
| wdata | input | NB*BW (32) | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| q | output | NB*BW (32) | Read data, 0 when not driven |
| q_drive | output | 1 | High when `q` is actively driven |

## Verification
On every cycle the assertions check:
- the address load on a selecting strobe, and the fixed upper address bits while no strobe is low;
- the one-step counter movement in linear mode, the change of beat in interleaved mode, and the hold when `adv_n` is high;
- the all-lanes mask of a global write, and the read-only start of a processor strobe;
- the output-enable gating, and the two-edge deselect bound.

Only the bench scenarios can show the values of the data: the exact beat order for each start offset, the 3-1-1-1 arrival, the byte-lane merge against the old contents, and that ignored address, strobe and write inputs leave the array unchanged.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;

   localparam int BEATS     = 4;
   localparam int BEAT_BITS = 2;

   // Low address bits of the current beat, from the start offset and the
   // beat count. Interleaved order XORs them; linear order adds mod 4.
   function automatic logic [BEAT_BITS-1:0] beat_low(
      input logic [BEAT_BITS-1:0] start,
      input logic [BEAT_BITS-1:0] cnt,
      input logic                 lin
   );
      logic [BEAT_BITS-1:0] r;
      if (lin) r = start + cnt;
      else     r = start ^ cnt;
      return r;
   endfunction

endpackage

// File: rtl/sram_fe_decode.sv
module sram_fe_decode #(
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe_proc_n,
   input  logic          strobe_ctrl_n,
   input  logic          adv_n,
   input  logic          en0_n,
   input  logic          en1,
   input  logic          en2_n,
   input  logic          all_wr_n,
   input  logic          byte_gate_n,
   input  logic [NB-1:0] byte_we_n,
   output logic          load,
   output logic          step,
   output logic          sel_q,
   output logic          rd_act_q,
   output logic          wr_pend_q,
   output logic [NB-1:0] wmask_q
);

   logic          chip_ok;
   logic          is_write;
   logic          wr_mode_q;
   logic [NB-1:0] mask_in;

   assign load    = ~strobe_proc_n | ~strobe_ctrl_n;
   assign chip_ok = ~en0_n & en1 & ~en2_n;
   // the processor strobe wins and always reads
   assign is_write = strobe_proc_n & ~strobe_ctrl_n & (~all_wr_n | ~byte_gate_n);
   assign step     = ~load & sel_q & ~adv_n;

   always_comb begin
      if (!all_wr_n)         mask_in = '1;
      else if (!byte_gate_n) mask_in = ~byte_we_n;
      else                   mask_in = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q     <= 1'b0;
         rd_act_q  <= 1'b0;
         wr_mode_q <= 1'b0;
         wr_pend_q <= 1'b0;
         wmask_q   <= '0;
      end else if (load) begin
         sel_q     <= chip_ok;
         rd_act_q  <= chip_ok & ~is_write;
         wr_mode_q <= chip_ok & is_write;
         wr_pend_q <= chip_ok & is_write;
         if (is_write) wmask_q <= mask_in;
      end else begin
         wr_pend_q <= step & wr_mode_q;
      end
   end

endmodule

// File: rtl/sram_fe_burst.sv
module sram_fe_burst
   import sram_fe_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [AW-1:0] addr,
   input  logic          burst_lin,
   output logic [AW-1:0] cur_addr,
   output logic          lin_q
);

   logic [AW-1:0]        base_q;
   logic [BEAT_BITS-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         lin_q  <= 1'b0;
      end else if (load) begin
         base_q <= addr;
         cnt_q  <= '0;
         lin_q  <= burst_lin;
      end else if (step) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign cur_addr = {base_q[AW-1:BEAT_BITS],
                      beat_low(base_q[BEAT_BITS-1:0], cnt_q, lin_q)};

endmodule

// File: rtl/sram_fe_lane_merge.sv
module sram_fe_lane_merge #(
   parameter int NB = 4,
   parameter int BW = 8
) (
   input  logic [NB-1:0]    mask,
   input  logic [NB*BW-1:0] old_d,
   input  logic [NB*BW-1:0] new_d,
   output logic [NB*BW-1:0] merged
);

   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign merged[i*BW +: BW] = mask[i] ? new_d[i*BW +: BW] : old_d[i*BW +: BW];
   end

endmodule

// File: rtl/sram_fe_array_pipe.sv
module sram_fe_array_pipe #(
   parameter int AW = 6,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cur_addr,
   input  logic          wr_commit,
   input  logic [DW-1:0] wr_word,
   input  logic          rd_act,
   input  logic          sel,
   output logic [DW-1:0] old_word,
   output logic [DW-1:0] q_reg,
   output logic          q_valid
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] s1_data;
   logic          s1_valid;

   assign old_word = mem[cur_addr];

   always_ff @(posedge clk) begin
      if (wr_commit) mem[cur_addr] <= wr_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_data  <= '0;
         s1_valid <= 1'b0;
         q_reg    <= '0;
         q_valid  <= 1'b0;
      end else begin
         s1_data  <= mem[cur_addr];
         s1_valid <= rd_act & sel;
         q_reg    <= s1_data;
         // a deselect drops a beat still in the array stage
         q_valid  <= s1_valid & sel;
      end
   end

endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front #(
   parameter int AW = 6,
   parameter int NB = 4,
   parameter int BW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             strobe_proc_n,
   input  logic             strobe_ctrl_n,
   input  logic             adv_n,
   input  logic             burst_lin,
   input  logic             en0_n,
   input  logic             en1,
   input  logic             en2_n,
   input  logic             all_wr_n,
   input  logic             byte_gate_n,
   input  logic [NB-1:0]    byte_we_n,
   input  logic [NB*BW-1:0] wdata,
   input  logic             oe_n,
   output logic [NB*BW-1:0] q,
   output logic             q_drive
);

   localparam int DW = NB * BW;

   if (AW < 2) begin : g_bad_aw
      $error("burst_sram_front: AW must be at least 2");
   end
   if (NB < 1 || BW < 1) begin : g_bad_lane
      $error("burst_sram_front: NB and BW must be positive");
   end

   logic          load;
   logic          step;
   logic          sel_q;
   logic          rd_act_q;
   logic          wr_pend_q;
   logic [NB-1:0] wmask_q;
   logic [AW-1:0] cur_addr;
   logic          lin_q;
   logic [DW-1:0] old_word;
   logic [DW-1:0] wr_word;
   logic [DW-1:0] q_reg;
   logic          q_valid;

   sram_fe_decode #(.NB(NB)) u_decode (
      .clk(clk), .rst_n(rst_n),
      .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
      .adv_n(adv_n), .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
      .all_wr_n(all_wr_n), .byte_gate_n(byte_gate_n), .byte_we_n(byte_we_n),
      .load(load), .step(step), .sel_q(sel_q), .rd_act_q(rd_act_q),
      .wr_pend_q(wr_pend_q), .wmask_q(wmask_q)
   );

   sram_fe_burst #(.AW(AW)) u_burst (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .addr(addr), .burst_lin(burst_lin),
      .cur_addr(cur_addr), .lin_q(lin_q)
   );

   sram_fe_lane_merge #(.NB(NB), .BW(BW)) u_merge (
      .mask(wmask_q), .old_d(old_word), .new_d(wdata), .merged(wr_word)
   );

   sram_fe_array_pipe #(.AW(AW), .DW(DW)) u_pipe (
      .clk(clk), .rst_n(rst_n), .cur_addr(cur_addr),
      .wr_commit(wr_pend_q), .wr_word(wr_word),
      .rd_act(rd_act_q), .sel(sel_q),
      .old_word(old_word), .q_reg(q_reg), .q_valid(q_valid)
   );

   assign q_drive = q_valid & ~oe_n;
   assign q       = q_drive ? q_reg : '0;

endmodule

// File: rtl/sram_fe_checker.sv
module sram_fe_checker #(
   parameter int AW = 6,
   parameter int NB = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] addr,
   input logic          strobe_proc_n,
   input logic          strobe_ctrl_n,
   input logic          adv_n,
   input logic          en0_n,
   input logic          en1,
   input logic          en2_n,
   input logic          all_wr_n,
   input logic          oe_n,
   input logic          q_drive,
   input logic [AW-1:0] cur_addr,
   input logic          sel_q,
   input logic          lin_q,
   input logic [NB-1:0] wmask_q,
   input logic          wr_pend_q,
   input logic          q_valid
);

   logic strobe_any;
   logic chip_ok;
   assign strobe_any = ~strobe_proc_n | ~strobe_ctrl_n;
   assign chip_ok    = ~en0_n & en1 & ~en2_n;

   p_load_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_any && chip_ok) |=> cur_addr == $past(addr));

   p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_any) |=> $stable(cur_addr[AW-1:2]));

   p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_any && !adv_n && sel_q && lin_q)
      |=> cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1);

   p_interleave_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_any && !adv_n && sel_q && !lin_q)
      |=> cur_addr[1:0] != $past(cur_addr[1:0]));

   p_hold_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_any && adv_n) |=> $stable(cur_addr));

   p_proc_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_proc_n) |=> !wr_pend_q);

   p_global_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_proc_n && !strobe_ctrl_n && chip_ok && !all_wr_n)
      |=> wmask_q == '1);

   p_oe_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !q_drive);

   p_deselect_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_any && !chip_ok) |=> ##1 !q_valid);

endmodule

bind burst_sram_front sram_fe_checker #(.AW(AW), .NB(NB)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr),
   .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
   .adv_n(adv_n), .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
   .all_wr_n(all_wr_n), .oe_n(oe_n), .q_drive(q_drive),
   .cur_addr(cur_addr), .sel_q(sel_q), .lin_q(lin_q),
   .wmask_q(wmask_q), .wr_pend_q(wr_pend_q), .q_valid(q_valid)
);

// File: tb/burst_sram_front_bench.sv
`timescale 1ns/1ps
module burst_sram_front_bench;

   localparam int AW = 6;
   localparam int NB = 4;
   localparam int BW = 8;
   localparam int DW = NB * BW;

   // {start address, linear flag, beat low bits b0 b1 b2 b3}
   localparam logic [14:0] TBL [8] = '{
      {6'd4,  1'b0, 8'b00_01_10_11},
      {6'd5,  1'b0, 8'b01_00_11_10},
      {6'd10, 1'b0, 8'b10_11_00_01},
      {6'd15, 1'b0, 8'b11_10_01_00},
      {6'd20, 1'b1, 8'b00_01_10_11},
      {6'd25, 1'b1, 8'b01_10_11_00},
      {6'd42, 1'b1, 8'b10_11_00_01},
      {6'd63, 1'b1, 8'b11_00_01_10}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          strobe_proc_n = 1'b1, strobe_ctrl_n = 1'b1, adv_n = 1'b1;
   logic          burst_lin = 1'b0;
   logic          en0_n = 1'b0, en1 = 1'b1, en2_n = 1'b0;
   logic          all_wr_n = 1'b1, byte_gate_n = 1'b1;
   logic [NB-1:0] byte_we_n = '1;
   logic [DW-1:0] wdata = '0;
   logic          oe_n = 1'b0;
   logic [DW-1:0] q;
   logic          q_drive;

   int errors = 0;
   int checks = 0;
   logic [DW-1:0] model [1 << AW];

   always #2 clk = ~clk;

   burst_sram_front #(.AW(AW), .NB(NB), .BW(BW)) u_burst_sram_front (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
      .adv_n(adv_n), .burst_lin(burst_lin),
      .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
      .all_wr_n(all_wr_n), .byte_gate_n(byte_gate_n), .byte_we_n(byte_we_n),
      .wdata(wdata), .oe_n(oe_n), .q(q), .q_drive(q_drive)
   );

   function automatic logic [DW-1:0] fill_val(input int i);
      return 32'h5A00_0000 ^ (32'(i) * 32'h0001_0203);
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_q(input string req, input logic [DW-1:0] exp);
      chk(q_drive === 1'b1 && q === exp, req, q, exp);
   endtask

   // four-beat global write, advancing on each data edge
   task automatic wr_burst(input logic [AW-1:0] base, input logic lin);
      addr = base; burst_lin = lin; strobe_ctrl_n = 1'b0; all_wr_n = 1'b0;
      adv_n = 1'b1;
      step();
      strobe_ctrl_n = 1'b1; all_wr_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         wdata = fill_val(int'(base) + k);
         model[int'(base) + k] = wdata;
         adv_n = (k == 3) ? 1'b1 : 1'b0;
         step();
      end
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // reset state
      chk(q_drive === 1'b0 && q === '0, "R11 reset idle", q, '0);

      // fill the array: R8
      for (int b = 0; b < 16; b++) wr_burst(6'(b * 4), 1'(b % 2));

      // R4 / R5 / R6: walk the order table with 3-1-1-1 reads
      for (int r = 0; r < 8; r++) begin
         logic [AW-1:0] base;
         logic [7:0]    seq;
         base = TBL[r][14:9];
         seq  = TBL[r][7:0];
         addr = base; burst_lin = TBL[r][8]; strobe_proc_n = 1'b0; adv_n = 1'b1;
         step();
         strobe_proc_n = 1'b0; strobe_proc_n = 1'b1; adv_n = 1'b0;
         step();
         step();
         for (int k = 0; k < 4; k++) begin
            check_q(TBL[r][8] ? "R5 linear beat" : "R4 interleaved beat",
                    model[{base[AW-1:2], seq[7-2*k -: 2]}]);
            if (k == 0) adv_n = 1'b0;
            if (k == 1) adv_n = 1'b1;
            step();
         end
      end

      // R1 / R6: address ignored without strobe, beat held without advance
      addr = 6'd8; burst_lin = 1'b0; strobe_proc_n = 1'b0; adv_n = 1'b1;
      step();
      strobe_proc_n = 1'b1; addr = 6'd40;
      step(); step();
      check_q("R1 addr ignored", model[8]);
      addr = 6'd50;
      step();
      check_q("R6 beat held", model[8]);

      // R11: output enable gates only the outputs
      oe_n = 1'b1; adv_n = 1'b0;
      #1;
      chk(q_drive === 1'b0 && q === '0, "R11 oe off", q, '0);
      step();
      adv_n = 1'b1;
      step(); step();
      chk(q_drive === 1'b0, "R11 oe still off", q, '0);
      oe_n = 1'b0;
      #1;
      check_q("R11 pipeline ran", model[9]);

      // R12: single-cycle deselect
      @(negedge clk);
      addr = 6'd0; en1 = 1'b0; strobe_proc_n = 1'b0;
      step();
      check_q("R12 one edge later", model[9]);
      strobe_proc_n = 1'b1; en1 = 1'b1;
      step();
      chk(q_drive === 1'b0, "R12 deselected", q, '0);

      // R3: first beat after the second edge from an idle state
      addr = 6'd33; strobe_proc_n = 1'b0;
      step();
      strobe_proc_n = 1'b1;
      chk(q_drive === 1'b0, "R3 edge1", q, '0);
      step();
      chk(q_drive === 1'b0, "R3 edge2", q, '0);
      step();
      check_q("R3 first beat", model[33]);

      // R2: each enable alone deselects
      for (int e = 0; e < 3; e++) begin
         addr = 6'd12; strobe_proc_n = 1'b0;
         step();
         strobe_proc_n = 1'b1;
         step(); step();
         check_q("R2 selected", model[12]);
         en0_n = (e == 0); en1 = (e != 1); en2_n = (e == 2);
         strobe_proc_n = 1'b0;
         step();
         strobe_proc_n = 1'b1; en0_n = 1'b0; en1 = 1'b1; en2_n = 1'b0;
         step();
         chk(q_drive === 1'b0, "R2 enable mismatch", q, '0);
      end

      // R7: processor strobe wins over a controller write
      addr = 6'd17; strobe_proc_n = 1'b0; strobe_ctrl_n = 1'b0; all_wr_n = 1'b0;
      wdata = '1;
      step();
      strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b1; all_wr_n = 1'b1;
      step(); step();
      check_q("R7 read", model[17]);
      step();
      check_q("R7 no write", model[17]);

      // R9: byte-lane write, lanes 1 and 3
      addr = 6'd21; strobe_ctrl_n = 1'b0; byte_gate_n = 1'b0; byte_we_n = 4'b0101;
      step();
      strobe_ctrl_n = 1'b1; byte_gate_n = 1'b1; byte_we_n = '1;
      wdata = 32'hDEAD_BEEF;
      step();
      model[21] = {8'hDE, model[21][23:16], 8'hBE, model[21][7:0]};
      // R8: global write overrides a single-lane enable
      addr = 6'd23; strobe_ctrl_n = 1'b0; all_wr_n = 1'b0; byte_gate_n = 1'b0;
      byte_we_n = 4'b1110;
      step();
      strobe_ctrl_n = 1'b1; all_wr_n = 1'b1; byte_gate_n = 1'b1; byte_we_n = '1;
      wdata = 32'h1357_9BDF;
      step();
      model[23] = 32'h1357_9BDF;
      // R10: controller strobe without write controls is a read
      addr = 6'd22; strobe_ctrl_n = 1'b0; byte_we_n = '0;
      step();
      strobe_ctrl_n = 1'b1; byte_we_n = '1; wdata = '0;
      step(); step();
      check_q("R10 read", model[22]);
      step();
      check_q("R10 unchanged", model[22]);

      addr = 6'd21; strobe_proc_n = 1'b0;
      step();
      strobe_proc_n = 1'b1;
      step(); step();
      check_q("R9 lane merge", model[21]);
      addr = 6'd23; strobe_proc_n = 1'b0;
      step();
      strobe_proc_n = 1'b1;
      step(); step();
      check_q("R8 global over lanes", model[23]);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule